// File: doc/BRIEF.md
# Interrupt Acknowledge Deferral Controller

This block decides, at every instruction boundary of a small CPU core, whether a pending interrupt is taken. It holds eight maskable request flags, a pending non-maskable request and the global interrupt-enable flag. The core's instruction sequencer tells it when an instruction completes and which class that instruction belongs to. When an interrupt is accepted, the block emits a three-step sequence of strobes: acknowledge together with save-status, then save-PC, then jump. The selected vector index is held steady on the output throughout.

Certain instructions open a one-instruction window in which no interrupt is taken. These are anything that touches the status word or the interrupt control registers, enable, disable, and the two return instructions. A request that is pending when such an instruction ends is held until the following instruction ends. A run of such instructions keeps pushing acceptance back. The software-break instruction is not in that class, but it drops the enable flag. Maskable sources therefore stay quiet across it, while the non-maskable source still gets through.

Top module: `irq_defer_ctrl`

## Requirements
- R1: A 1 on bit i of `req_set_i` sets bit i of `req_flags_o` one cycle later, whatever `mask_i` and `prio_i` hold; the flag stays set until that source is acknowledged.
- R2: An interrupt is accepted only on a clock edge where `instr_done_i` is 1 and no acknowledge sequence is in progress; `ack_o` never rises otherwise.
- R3: Class codes 1 (status/interrupt-register access), 3 (enable), 4 (disable) and 5 (return) are reserve codes. No interrupt is accepted at the completion of a reserve-code instruction. The next completing instruction whose code is not a reserve code may accept, so consecutive reserve instructions keep extending the hold.
- R4: Maskable source i is eligible when its flag is 1, `mask_i[i]` is 0 and the enable flag is 1. Sources with `prio_i[i]`=1 beat sources with 0. Within one level the lowest index wins, and `vector_o` equals that index.
- R5: A pulse on `nmi_i` latches a non-maskable request. It outranks every maskable source, ignores masks and the enable flag, uses vector 15, and is still held back by R3.
- R6: Class code 2 (software break) is not a reserve code. At its completion the enable flag is cleared, no maskable source is accepted, and a pending non-maskable request is accepted.
- R7: At completion, code 3 sets the enable flag, codes 4 and 2 clear it, and code 5 sets it. Codes 0, 1, 6 and 7 leave it unchanged. `ie_o` shows the flag.
- R8: In the cycle after acceptance, `ack_o` and `save_psw_o` are 1 for one cycle. `save_pc_o` is 1 in the next cycle, and `jump_o` in the cycle after that. `vector_o` does not change across these three cycles.
- R9: Accepting a maskable source clears the enable flag and that source's flag, both already visible in the cycle where `ack_o` is 1. Accepting the non-maskable request leaves the enable flag and all maskable flags unchanged.
- R10: A clock edge with `rst_n` low clears all flags, the pending non-maskable request and the enable flag, drives all strobes low and sets `vector_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_set_i | input | 8 | Per-source request event, one bit per maskable source |
| mask_i | input | 8 | Per-source mask, 1 blocks the source |
| prio_i | input | 8 | Per-source priority, 1 is the high level |
| nmi_i | input | 1 | Non-maskable request event |
| instr_done_i | input | 1 | Instruction completes in this cycle |
| instr_class_i | input | 3 | Class code of the completing instruction |
| ack_o | output | 1 | Interrupt acknowledged |
| vector_o | output | 4 | Selected vector, 0-7 maskable, 15 non-maskable |
| save_psw_o | output | 1 | Core saves the status word |
| save_pc_o | output | 1 | Core saves the program counter |
| jump_o | output | 1 | Core jumps to the service routine |
| ie_o | output | 1 | Global interrupt-enable flag |
| req_flags_o | output | 8 | Latched maskable request flags |

## Verification
The hardest situation to reach is a request held back across a chain of reserve instructions and then released by exactly the right boundary. The stimulus gets there by first latching a request with enable already set, and only then stepping instruction completions with chosen class codes. It checks `ack_o` after each completion. A break completion with both a maskable and a non-maskable request pending is driven the same way, so that the split between the two kinds of source is seen at a single boundary.

// File: rtl/irq_defer_pkg.sv
// Shared types and helpers for the interrupt acknowledge deferral controller.
// Assumes class codes arrive as a 3-bit field from the instruction decoder.
package irq_defer_pkg;

    typedef enum logic [2:0] {
        CLS_PLAIN = 3'd0,
        CLS_RSV   = 3'd1,
        CLS_BRK   = 3'd2,
        CLS_EI    = 3'd3,
        CLS_DI    = 3'd4,
        CLS_RET   = 3'd5
    } instr_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PSW  = 2'd1,
        ST_PC   = 2'd2,
        ST_JMP  = 2'd3
    } ack_state_e;

    // True when the class code opens a one-instruction acceptance hold.
    function automatic logic is_reserve(input logic [2:0] cls);
        return (cls == CLS_RSV) || (cls == CLS_EI) ||
               (cls == CLS_DI)  || (cls == CLS_RET);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
// Request flag bank: one sticky flag per maskable source.
// A set event wins over a clear of the same bit in the same cycle.
// Assumes a synchronous active-low reset.
module irq_flag_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
            // Hold, set or clear one source flag.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags_o[g] <= 1'b0;
                else if (set_i[g])
                    flags_o[g] <= 1'b1;
                else if (clr_i[g])
                    flags_o[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_pick.sv
// Two-level fixed selector: any high-priority eligible source beats every
// low-priority one; inside a level the lowest index wins.
// Purely combinational; assumes eligibility is already qualified.
module irq_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] elig_i,
    input  logic [NUM_SRC-1:0] prio_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_SRC-1:0] hi_vec;
    logic               hi_hit, lo_hit;
    logic [IDX_W-1:0]   hi_idx, lo_idx;

    assign hi_vec = elig_i & prio_i;

    // Scan downward so the lowest set index is the last one kept.
    always_comb begin
        hi_hit = 1'b0;
        lo_hit = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hi_vec[i]) begin
                hi_hit = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (elig_i[i]) begin
                lo_hit = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
    end

    // Merge the two levels.
    assign hit_o = lo_hit;
    assign idx_o = hi_hit ? hi_idx : lo_idx;

endmodule

// File: rtl/irq_defer_ctrl.sv
// Interrupt acknowledge deferral controller (top).
// At each completed instruction, decides whether the pending non-maskable
// request or the best eligible maskable source is accepted, honouring the
// one-instruction hold after reserve-class instructions and the enable drop
// caused by a software break. On acceptance it walks a three-cycle strobe
// sequence: acknowledge + save status, save PC, jump.
// Assumes the core raises instr_done_i only while no sequence is running and
// supplies the class code of the completing instruction in the same cycle.
module irq_defer_ctrl
    import irq_defer_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4,
    parameter int NMI_VEC = 15,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_set_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               nmi_i,
    input  logic               instr_done_i,
    input  logic [2:0]         instr_class_i,
    output logic               ack_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic               save_psw_o,
    output logic               save_pc_o,
    output logic               jump_o,
    output logic               ie_o,
    output logic [NUM_SRC-1:0] req_flags_o
);

    ack_state_e         state_q, state_d;
    logic               ie_q, ie_d;
    logic               nmi_pend_q;
    logic [VEC_W-1:0]   vec_q;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] clr_vec;
    logic               ie_eff;
    logic               boundary, held, take, take_nmi, take_msk;
    logic               pick_hit;
    logic [IDX_W-1:0]   pick_idx;

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (req_set_i),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    // A completing break already counts as enable-low for maskable sources.
    assign ie_eff = ie_q && (instr_class_i != CLS_BRK);
    assign elig   = flags & ~mask_i & {NUM_SRC{ie_eff}};

    irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .elig_i (elig),
        .prio_i (prio_i),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx)
    );

    // Acceptance decision at an instruction boundary.
    assign boundary = (state_q == ST_IDLE) && instr_done_i;
    assign held     = is_reserve(instr_class_i);
    assign take     = boundary && !held && (nmi_pend_q || pick_hit);
    assign take_nmi = take && nmi_pend_q;
    assign take_msk = take && !nmi_pend_q;

    // Clear request for the accepted maskable source.
    always_comb begin
        clr_vec = '0;
        if (take_msk)
            clr_vec[pick_idx] = 1'b1;
    end

    // Next value of the global enable flag.
    always_comb begin
        ie_d = ie_q;
        if (take_msk)
            ie_d = 1'b0;
        else if (boundary) begin
            unique case (instr_class_i)
                CLS_EI, CLS_RET: ie_d = 1'b1;
                CLS_DI, CLS_BRK: ie_d = 1'b0;
                default:         ie_d = ie_q;
            endcase
        end
    end

    // Strobe sequence after acceptance.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_PSW : ST_IDLE;
            ST_PSW:  state_d = ST_PC;
            ST_PC:   state_d = ST_JMP;
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state, enable, pending non-maskable request and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ie_q       <= 1'b0;
            nmi_pend_q <= 1'b0;
            vec_q      <= '0;
        end else begin
            state_q    <= state_d;
            ie_q       <= ie_d;
            nmi_pend_q <= nmi_i || (nmi_pend_q && !take_nmi);
            if (take)
                vec_q <= take_nmi ? VEC_W'(NMI_VEC) : VEC_W'(pick_idx);
        end
    end

    // Drive the outputs from registered state.
    assign ack_o       = (state_q == ST_PSW);
    assign save_psw_o  = (state_q == ST_PSW);
    assign save_pc_o   = (state_q == ST_PC);
    assign jump_o      = (state_q == ST_JMP);
    assign vector_o    = vec_q;
    assign ie_o        = ie_q;
    assign req_flags_o = flags;

endmodule

// File: rtl/irq_defer_chk.sv
// Property checker for irq_defer_ctrl, attached by bind below.
// Observes ports only; assumes the synchronous active-low reset.
module irq_defer_chk #(
    parameter int VEC_W   = 4,
    parameter int NMI_VEC = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_done_i,
    input logic [2:0]       instr_class_i,
    input logic             ack_o,
    input logic             save_psw_o,
    input logic             save_pc_o,
    input logic             jump_o,
    input logic             ie_o,
    input logic [VEC_W-1:0] vector_o
);

    a_r2_ack_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(instr_done_i));

    a_r3_no_ack_after_reserve: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> !($past(instr_class_i) == 3'd1 || $past(instr_class_i) == 3'd3 ||
                           $past(instr_class_i) == 3'd4 || $past(instr_class_i) == 3'd5));

    a_r8_psw_then_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> (save_pc_o && !ack_o));

    a_r8_pc_then_jump: assert property (@(posedge clk) disable iff (!rst_n)
        save_pc_o |=> jump_o);

    a_r8_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (save_pc_o || jump_o) |-> $stable(vector_o));

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_psw_o, save_pc_o, jump_o}));

    a_r9_ie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && vector_o != VEC_W'(NMI_VEC)) |-> !ie_o);

endmodule

bind irq_defer_ctrl irq_defer_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (.*);

// File: tb/irq_defer_ctrl_tb_top.sv
// Self-checking bench for irq_defer_ctrl: table-driven acceptance cases,
// then directed tests for reset, deferral chains, sequencing and flags.
module irq_defer_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_set_i, mask_i, prio_i;
    logic       nmi_i, instr_done_i;
    logic [2:0] instr_class_i;
    logic       ack_o, save_psw_o, save_pc_o, jump_o, ie_o;
    logic [3:0] vector_o;
    logic [7:0] req_flags_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_defer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_set_i(req_set_i), .mask_i(mask_i),
        .prio_i(prio_i), .nmi_i(nmi_i), .instr_done_i(instr_done_i),
        .instr_class_i(instr_class_i), .ack_o(ack_o), .vector_o(vector_o),
        .save_psw_o(save_psw_o), .save_pc_o(save_pc_o), .jump_o(jump_o),
        .ie_o(ie_o), .req_flags_o(req_flags_o)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] mask;
        logic [7:0] prio;
        logic       nmi;
        logic       en;
        logic [2:0] cls;
        logic       ack;
        logic [3:0] vec;
    } case_t;

    localparam int NCASE = 13;
    localparam case_t TBL [NCASE] = '{
        '{8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 1'b1, 4'd0},   // R4 single source
        '{8'h0C, 8'h00, 8'h08, 1'b0, 1'b1, 3'd0, 1'b1, 4'd3},   // R4 high level beats lower index
        '{8'hA0, 8'h00, 8'hA0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd5},   // R4 lowest index in high level
        '{8'h06, 8'h02, 8'h00, 1'b0, 1'b1, 3'd0, 1'b1, 4'd2},   // R4 masked source skipped
        '{8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 4'd0},   // R4 enable low
        '{8'h01, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 4'd15},  // R5 ignores enable
        '{8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 3'd0, 1'b1, 4'd15},  // R5 outranks maskable
        '{8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0, 4'd0},   // R3 reserve holds
        '{8'h01, 8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 1'b0, 4'd0},   // R6 break blocks maskable
        '{8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 3'd2, 1'b1, 4'd15},  // R6 break passes nmi
        '{8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 3'd4, 1'b0, 4'd0},   // R5 nmi held by reserve
        '{8'h10, 8'h10, 8'h00, 1'b0, 1'b1, 3'd0, 1'b0, 4'd0},   // R4 only source masked
        '{8'h80, 8'h00, 8'h00, 1'b0, 1'b1, 3'd6, 1'b1, 4'd7}    // R4 unused code behaves plain
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_set_i = '0; mask_i = '0; prio_i = '0;
        nmi_i = 1'b0; instr_done_i = 1'b0; instr_class_i = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Complete one instruction of class cls; returns at the negedge after.
    task automatic instr(input logic [2:0] cls);
        instr_done_i = 1'b1; instr_class_i = cls;
        @(negedge clk);
        instr_done_i = 1'b0; instr_class_i = 3'd0;
    endtask

    task automatic pulse(input logic [7:0] r, input logic n);
        req_set_i = r; nmi_i = n;
        @(negedge clk);
        req_set_i = '0; nmi_i = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        req_set_i = '0; mask_i = '0; prio_i = '0;
        nmi_i = 1'b0; instr_done_i = 1'b0; instr_class_i = 3'd0;

        // R10 reset state
        do_reset();
        check(ack_o == 0 && save_psw_o == 0 && save_pc_o == 0 && jump_o == 0,
              "R10 strobes low", {ack_o, save_psw_o, save_pc_o, jump_o}, 0);
        check(ie_o == 0, "R10 enable clear", ie_o, 0);
        check(req_flags_o == 0, "R10 flags clear", req_flags_o, 0);
        check(vector_o == 0, "R10 vector zero", vector_o, 0);

        // Table of acceptance cases
        for (int k = 0; k < NCASE; k++) begin
            do_reset();
            mask_i = TBL[k].mask; prio_i = TBL[k].prio;
            if (TBL[k].en) instr(3'd3);
            pulse(TBL[k].req, TBL[k].nmi);
            instr(TBL[k].cls);
            check(ack_o == TBL[k].ack, $sformatf("R4/R5/R3/R6 case %0d ack", k), ack_o, TBL[k].ack);
            if (TBL[k].ack)
                check(vector_o == TBL[k].vec, $sformatf("R4/R5 case %0d vector", k), vector_o, TBL[k].vec);
        end

        // R1 latching ignores mask and priority
        do_reset();
        mask_i = 8'h21; prio_i = 8'h01;
        pulse(8'h21, 1'b0);
        check(req_flags_o == 8'h21, "R1 flags latched", req_flags_o, 8'h21);
        repeat (3) @(negedge clk);
        check(req_flags_o == 8'h21, "R1 flags sticky", req_flags_o, 8'h21);

        // R2 no acceptance without a completion
        do_reset();
        instr(3'd3);
        pulse(8'h04, 1'b0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(ack_o == 0, "R2 idle no ack", ack_o, 0);
        end
        instr(3'd0);
        check(ack_o == 1 && vector_o == 2, "R2 ack at boundary", {ack_o, vector_o}, {1'b1, 4'd2});

        // R3 chain of reserve instructions extends the hold
        do_reset();
        instr(3'd3);
        pulse(8'h02, 1'b0);
        instr(3'd1);
        check(ack_o == 0, "R3 first reserve", ack_o, 0);
        instr(3'd5);
        check(ack_o == 0, "R3 second reserve", ack_o, 0);
        instr(3'd1);
        check(ack_o == 0, "R3 third reserve", ack_o, 0);
        instr(3'd0);
        check(ack_o == 1, "R3 released", ack_o, 1);
        // R8 and R9 on the same acceptance
        check(save_psw_o == 1 && vector_o == 1, "R8 save status", {save_psw_o, vector_o}, {1'b1, 4'd1});
        check(ie_o == 0, "R9 enable cleared", ie_o, 0);
        check(req_flags_o == 0, "R9 flag cleared", req_flags_o, 0);
        @(negedge clk);
        check(save_pc_o == 1 && ack_o == 0 && vector_o == 1, "R8 save pc",
              {save_pc_o, ack_o, vector_o}, {1'b1, 1'b0, 4'd1});
        @(negedge clk);
        check(jump_o == 1 && save_pc_o == 0 && vector_o == 1, "R8 jump",
              {jump_o, save_pc_o, vector_o}, {1'b1, 1'b0, 4'd1});
        @(negedge clk);
        check(jump_o == 0 && ack_o == 0, "R8 sequence ends", {jump_o, ack_o}, 0);

        // R9 non-maskable acceptance leaves enable and flags
        do_reset();
        mask_i = 8'h01;
        instr(3'd3);
        pulse(8'h01, 1'b1);
        instr(3'd0);
        check(ack_o == 1 && vector_o == 15, "R9 nmi accepted", {ack_o, vector_o}, {1'b1, 4'd15});
        check(ie_o == 1, "R9 nmi keeps enable", ie_o, 1);
        check(req_flags_o == 8'h01, "R9 nmi keeps flags", req_flags_o, 8'h01);
        drain();

        // R7 enable flag updates per class
        instr(3'd4);
        check(ie_o == 0, "R7 disable", ie_o, 0);
        instr(3'd5);
        check(ie_o == 1, "R7 return sets", ie_o, 1);
        instr(3'd1);
        check(ie_o == 1, "R7 reserve keeps", ie_o, 1);
        instr(3'd2);
        check(ie_o == 0, "R6 break clears enable", ie_o, 0);
        instr(3'd0);
        check(ie_o == 0, "R7 plain keeps", ie_o, 0);
        instr(3'd3);
        check(ie_o == 1, "R7 enable sets", ie_o, 1);

        // R6 break with both kinds pending: nmi taken, maskable flag kept
        do_reset();
        instr(3'd3);
        pulse(8'h08, 1'b1);
        instr(3'd2);
        check(ack_o == 1 && vector_o == 15, "R6 nmi through break", {ack_o, vector_o}, {1'b1, 4'd15});
        check(req_flags_o == 8'h08 && ie_o == 0, "R6 maskable left pending",
              {req_flags_o, ie_o}, {8'h08, 1'b0});
        drain();
        instr(3'd0);
        check(ack_o == 0, "R6 maskable stays off after break", ack_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule